// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drains a circular list of transmit descriptors kept in system memory and turns the buffers they point at into an outgoing byte stream. Each descriptor occupies two 32-bit words. The first word holds a 16-bit flag field in its upper half and a 16-bit byte count in its lower half. The second word holds the buffer's start address. When software pulses the activate input, the walker reads the descriptor at its current pointer. If that descriptor is marked ready, the walker streams its bytes out, hands ownership back by rewriting the header with the ready flag cleared, and moves on to the next descriptor. It stops when it meets a descriptor that is not ready, and it keeps its pointer for the next pulse.

Several consecutive descriptors can make up one frame. A frame ends at a descriptor whose last flag is set, and only the final byte of that descriptor carries the stream's end marker. The walker keeps a running byte count for the frame and enforces a hard limit of MAX_FRAME bytes. A buffer that would cross the limit is cut short, and a babble event is pulsed. Three one-cycle event pulses report each consumed buffer, each completed frame and each truncation, so that an interrupt block can collect them.

Memory accesses use a word port. A request is held until the memory returns a one-cycle valid, and data travels big-endian: the byte at the lowest address sits in bits 31:24. Buffers may start at any byte alignment.

Top module: `txr_engine`

## Requirements
- R1: While reset is asserted and after it is released, mem_req, tx_valid, busy and all three event outputs are low.
- R2: An activate pulse while idle causes a read of the header word at the current pointer, then a read of the buffer address at pointer+4. The header's bits 31:16 are the flags and its bits 15:0 are the byte count.
- R3: A header whose ready flag is clear (flags bit 15, word bit 31) ends the walk. The walker returns to idle with no event and no output byte, and the next activation reads that same header address again.
- R4: The buffer bytes are emitted in ascending address order from any starting byte offset, using big-endian lanes. Each byte is transferred on a cycle with tx_valid and tx_ready both high. Successive descriptors of a frame form one continuous byte sequence.
- R5: tx_last is high only on the final byte of a descriptor whose last flag (flags bit 11) is set.
- R6: After the buffer is drained, the header word is written back to the descriptor address with only the ready flag cleared. This write completes before the next descriptor is read.
- R7: After the write-back, the pointer moves to the ring start when the wrap flag (flags bit 13) is set. Otherwise it moves to the descriptor address plus 8.
- R8: A ring-start write while idle loads both the ring start and the current pointer, with the low two address bits forced to zero.
- R9: ev_buf_done pulses once for every descriptor consumed. ev_frame_done pulses for each consumed descriptor that has the last flag set, and the frame byte count then restarts from zero.
- R10: When the frame byte count plus a descriptor's length would exceed MAX_FRAME (2032 by default), only the bytes that fit are emitted and ev_babble pulses once for that descriptor.
- R11: An activate pulse while busy has no effect. No further walk takes place once the current one ends.
- R12: While tx_valid is high and tx_ready is low, tx_data and tx_last hold. A memory request holds its address, direction and write data until mem_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| activate | input | 1 | One-cycle strobe that starts a walk from the current pointer |
| ring_base_we | input | 1 | Load strobe for the ring start address |
| ring_base_wdata | input | ADDR_W | New ring start address (low two bits ignored) |
| mem_req | output | 1 | Memory request, held until mem_valid |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Word-aligned memory byte address |
| mem_wdata | output | 32 | Write data (descriptor header write-back) |
| mem_valid | input | 1 | One-cycle completion of the current request |
| mem_rdata | input | 32 | Read data, valid with mem_valid |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | tx_data is valid |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Downstream accepts the byte this cycle |
| ev_buf_done | output | 1 | Pulse: a descriptor was consumed |
| ev_frame_done | output | 1 | Pulse: a frame-ending descriptor was consumed |
| ev_babble | output | 1 | Pulse: a buffer was truncated at the frame limit |
| busy | output | 1 | Walker is active |

## Verification
The hardest situation to reach is the frame limit. It needs more than 2032 bytes gathered across several descriptors, followed by a new frame that must start again from a count of zero. A directed ring supplies exactly that: a 2000-byte buffer, a 100-byte last buffer that is cut to 32 bytes, and a short frame after it. Wrap back onto an already cleared descriptor and a pointer kept across activations are also reached through directed rings. Randomized rings add odd buffer alignments, zero-length middle buffers, random flag bits that the write-back must preserve, random memory latency and random downstream stalls. All of these are checked against a bench model that walks its own copy of memory.

// File: rtl/txr_pkg.sv
package txr_pkg;
   localparam int WORD_W     = 32;
   localparam int LEN_W      = 16;
   localparam int FLG_READY  = 15;
   localparam int FLG_WRAP   = 13;
   localparam int FLG_LAST   = 11;
   localparam int DESC_BYTES = 8;

   typedef enum logic [2:0] {
      S_IDLE,
      S_HDR,
      S_PTR,
      S_CLIP,
      S_FETCH,
      S_SEND,
      S_WBACK
   } txr_state_e;
endpackage

// File: rtl/txr_byte_sel.sv
module txr_byte_sel #(
   parameter int LANES = 4
) (
   input  logic [8*LANES-1:0]         word_i,
   input  logic [$clog2(LANES)-1:0]   lane_i,
   output logic [7:0]                 byte_o
);
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("txr_byte_sel: LANES must be a power of two of at least 2");
   end

   logic [7:0] lanes [LANES];

   // Lowest byte address occupies the most significant lane
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lanes[g] = word_i[8*(LANES-1-g) +: 8];
   end

   assign byte_o = lanes[lane_i];
endmodule

// File: rtl/txr_len_clip.sv
module txr_len_clip #(
   parameter int LEN_W     = 16,
   parameter int CNT_W     = 11,
   parameter int MAX_FRAME = 2032
) (
   input  logic [LEN_W-1:0] req_len_i,
   input  logic [CNT_W-1:0] sofar_i,
   output logic [LEN_W-1:0] eff_len_o,
   output logic             cut_o
);
   localparam int CALC_W = ((LEN_W > CNT_W) ? LEN_W : CNT_W) + 1;

   if (MAX_FRAME >= (1 << LEN_W)) begin : g_bad_max
      $error("txr_len_clip: MAX_FRAME does not fit the length field");
   end

   logic [CALC_W-1:0] room;

   always_comb begin
      room      = CALC_W'(MAX_FRAME) - CALC_W'(sofar_i);
      cut_o     = CALC_W'(req_len_i) > room;
      eff_len_o = cut_o ? room[LEN_W-1:0] : req_len_i;
   end
endmodule

// File: rtl/txr_engine.sv
module txr_engine
   import txr_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int MAX_FRAME = 2032
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              activate,
   input  logic              ring_base_we,
   input  logic [ADDR_W-1:0] ring_base_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_valid,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [7:0]        tx_data,
   output logic              tx_valid,
   output logic              tx_last,
   input  logic              tx_ready,
   output logic              ev_buf_done,
   output logic              ev_frame_done,
   output logic              ev_babble,
   output logic              busy
);
   localparam int CNT_W   = $clog2(MAX_FRAME + 1);
   localparam int LANES   = WORD_W / 8;
   localparam int LANE_W  = $clog2(LANES);
   localparam logic [LEN_W-1:0] READY_CLR = ~(LEN_W'(1) << FLG_READY);

   if (ADDR_W < 12 || ADDR_W > WORD_W) begin : g_bad_addr
      $error("txr_engine: ADDR_W out of range");
   end
   if (MAX_FRAME < 1 || MAX_FRAME > 65535) begin : g_bad_max
      $error("txr_engine: MAX_FRAME out of range");
   end

   txr_state_e        state;
   logic [ADDR_W-1:0] cur_q, base_q, bptr_q;
   logic [LEN_W-1:0]  flags_q, len_q, left_q;
   logic [CNT_W-1:0]  sofar_q;
   logic [WORD_W-1:0] word_q;
   logic              cut_q;
   logic [LEN_W-1:0]  eff_len;
   logic              eff_cut;
   logic [ADDR_W-1:0] base_in;

   assign base_in = ring_base_wdata & ~ADDR_W'(3);

   txr_len_clip #(
      .LEN_W     (LEN_W),
      .CNT_W     (CNT_W),
      .MAX_FRAME (MAX_FRAME)
   ) u_clip (
      .req_len_i (len_q),
      .sofar_i   (sofar_q),
      .eff_len_o (eff_len),
      .cut_o     (eff_cut)
   );

   txr_byte_sel #(.LANES(LANES)) u_sel (
      .word_i (word_q),
      .lane_i (bptr_q[LANE_W-1:0]),
      .byte_o (tx_data)
   );

   // Memory port
   always_comb begin
      mem_req  = (state == S_HDR) || (state == S_PTR) ||
                 (state == S_FETCH) || (state == S_WBACK);
      mem_we   = (state == S_WBACK);
      unique case (state)
         S_HDR, S_WBACK: mem_addr = cur_q;
         S_PTR:          mem_addr = cur_q + ADDR_W'(4);
         S_FETCH:        mem_addr = {bptr_q[ADDR_W-1:LANE_W], LANE_W'(0)};
         default:        mem_addr = '0;
      endcase
   end
   assign mem_wdata = {flags_q & READY_CLR, len_q};

   assign tx_valid = (state == S_SEND);
   assign tx_last  = (state == S_SEND) && flags_q[FLG_LAST] && (left_q == LEN_W'(1));
   assign busy     = (state != S_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state         <= S_IDLE;
         cur_q         <= '0;
         base_q        <= '0;
         bptr_q        <= '0;
         flags_q       <= '0;
         len_q         <= '0;
         left_q        <= '0;
         sofar_q       <= '0;
         word_q        <= '0;
         cut_q         <= 1'b0;
         ev_buf_done   <= 1'b0;
         ev_frame_done <= 1'b0;
         ev_babble     <= 1'b0;
      end else begin
         ev_buf_done   <= 1'b0;
         ev_frame_done <= 1'b0;
         ev_babble     <= 1'b0;
         if (ring_base_we) begin
            base_q <= base_in;
            if (state == S_IDLE) cur_q <= base_in;
         end
         unique case (state)
            S_IDLE: if (activate) state <= S_HDR;
            S_HDR: if (mem_valid) begin
               flags_q <= mem_rdata[WORD_W-1 -: LEN_W];
               len_q   <= mem_rdata[LEN_W-1:0];
               state   <= mem_rdata[LEN_W + FLG_READY] ? S_PTR : S_IDLE;
            end
            S_PTR: if (mem_valid) begin
               bptr_q <= mem_rdata[ADDR_W-1:0];
               state  <= S_CLIP;
            end
            S_CLIP: begin
               left_q <= eff_len;
               cut_q  <= eff_cut;
               state  <= (eff_len == '0) ? S_WBACK : S_FETCH;
            end
            S_FETCH: if (mem_valid) begin
               word_q <= mem_rdata;
               state  <= S_SEND;
            end
            S_SEND: if (tx_ready) begin
               bptr_q  <= bptr_q + ADDR_W'(1);
               left_q  <= left_q - LEN_W'(1);
               sofar_q <= sofar_q + CNT_W'(1);
               if (left_q == LEN_W'(1))                  state <= S_WBACK;
               else if (&bptr_q[LANE_W-1:0])             state <= S_FETCH;
            end
            S_WBACK: if (mem_valid) begin
               ev_buf_done <= 1'b1;
               ev_babble   <= cut_q;
               if (flags_q[FLG_LAST]) begin
                  ev_frame_done <= 1'b1;
                  sofar_q       <= '0;
               end
               cur_q <= flags_q[FLG_WRAP] ? base_q : cur_q + ADDR_W'(DESC_BYTES);
               state <= S_HDR;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R12
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_valid |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   // R12
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

   // R6
   wb_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> !mem_wdata[LEN_W + FLG_READY]);

   // R9
   buf_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_buf_done |-> $past(mem_req && mem_we && mem_valid));

   // R10
   frame_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sofar_q <= CNT_W'(MAX_FRAME));
endmodule

// File: tb/tb_txr_engine.sv
module tb_txr_engine;
   localparam int MAXF = 2032;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        activate = 1'b0, ring_base_we = 1'b0;
   logic [31:0] ring_base_wdata = '0;
   logic        mem_req, mem_we, mem_valid = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
   logic [7:0]  tx_data;
   logic        tx_valid, tx_last, tx_ready = 1'b0;
   logic        ev_buf_done, ev_frame_done, ev_babble, busy;

   txr_engine dut (
      .clk(clk), .rst_n(rst_n), .activate(activate),
      .ring_base_we(ring_base_we), .ring_base_wdata(ring_base_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_valid(mem_valid), .mem_rdata(mem_rdata),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
      .ev_buf_done(ev_buf_done), .ev_frame_done(ev_frame_done), .ev_babble(ev_babble),
      .busy(busy)
   );

   logic [31:0] mem    [0:1023];
   logic [31:0] shadow [0:1023];
   logic [8:0]  exp_q[$];
   logic [8:0]  got_q[$];
   int nvec = 0, nfail = 0;
   int got_buf = 0, got_frame = 0, got_bab = 0;
   int exp_buf, exp_frame, exp_bab, hold_err = 0, lat = 0, sofar_exp = 0;
   int unsigned cur_exp = 0, base_exp = 0, start_exp = 0, first_addr = 0;
   bit cap_arm = 1'b0, rdy_rand = 1'b0, prev_stall = 1'b0;
   logic [8:0] prev_tx = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // Memory responder, downstream sink and event monitor
   initial begin
      forever begin
         @(negedge clk);
         tx_ready = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
         if (prev_stall && !(tx_valid && {tx_last, tx_data} == prev_tx)) hold_err++;
         if (tx_valid && tx_ready) got_q.push_back({tx_last, tx_data});
         prev_stall = tx_valid && !tx_ready;
         prev_tx    = {tx_last, tx_data};
         if (ev_buf_done)   got_buf++;
         if (ev_frame_done) got_frame++;
         if (ev_babble)     got_bab++;
         if (cap_arm && mem_req) begin
            first_addr = mem_addr;
            cap_arm    = 1'b0;
         end
         if (mem_valid) begin
            mem_valid = 1'b0;
            lat = $urandom % 3;
         end else if (mem_req) begin
            if (lat == 0) begin
               if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
               else        mem_rdata = mem[mem_addr[11:2]];
               mem_valid = 1'b1;
            end else lat--;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      nvec++;
      nfail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   task automatic put_desc(input int unsigned a, input logic [15:0] flg,
                           input logic [15:0] ln, input int unsigned ba);
      mem[(a >> 2) & 1023]       = {flg, ln};
      mem[((a >> 2) + 1) & 1023] = ba;
   endtask

   task automatic clear_desc();
      for (int i = 0; i < 64; i++) mem[i] = '0;
   endtask

   task automatic set_base(input int unsigned v);
      @(negedge clk);
      ring_base_we = 1'b1;
      ring_base_wdata = v;
      @(negedge clk);
      ring_base_we = 1'b0;
      base_exp = v & ~32'd3;
      cur_exp  = base_exp;
   endtask

   // Independent walk over a copy of memory
   task automatic model_walk();
      int unsigned p;
      p = cur_exp;
      start_exp = cur_exp;
      for (int i = 0; i < 1024; i++) shadow[i] = mem[i];
      exp_q.delete();
      exp_buf = 0; exp_frame = 0; exp_bab = 0;
      for (int it = 0; it < 64; it++) begin
         logic [31:0] w0, ba;
         int room, eff;
         w0 = shadow[(p >> 2) & 1023];
         if (!w0[31]) break;
         ba = shadow[((p >> 2) + 1) & 1023];
         room = MAXF - sofar_exp;
         if (int'(w0[15:0]) > room) begin
            eff = room;
            exp_bab++;
         end else eff = int'(w0[15:0]);
         for (int i = 0; i < eff; i++) begin
            int unsigned a;
            logic [31:0] w;
            a = ba + i;
            w = shadow[(a >> 2) & 1023];
            exp_q.push_back({(w0[27] && i == eff - 1), w[8*(3 - (a & 3)) +: 8]});
         end
         sofar_exp += eff;
         shadow[(p >> 2) & 1023] = w0 & 32'h7FFF_FFFF;
         exp_buf++;
         if (w0[27]) begin
            exp_frame++;
            sofar_exp = 0;
         end
         p = w0[29] ? base_exp : p + 8;
      end
      cur_exp = p;
   endtask

   task automatic do_run(input string ptr_req, input bit extra);
      int quiet, dmis, lmis, n, dsc;
      model_walk();
      got_q.delete();
      got_buf = 0; got_frame = 0; got_bab = 0; hold_err = 0;
      first_addr = 32'hFFFF_FFFF;
      cap_arm = 1'b1;
      @(negedge clk);
      activate = 1'b1;
      @(negedge clk);
      activate = 1'b0;
      if (extra) begin
         repeat (2) @(negedge clk);
         if (busy) begin
            activate = 1'b1;
            @(negedge clk);
            activate = 1'b0;
         end
      end
      while (busy) @(negedge clk);
      quiet = 0;
      repeat (20) begin
         @(negedge clk);
         if (mem_req || tx_valid || busy) quiet++;
      end
      chk(first_addr == start_exp, ptr_req, "first header address", first_addr, start_exp);
      chk(got_q.size() == exp_q.size(), "R4", "byte count", got_q.size(), exp_q.size());
      n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
      dmis = 0; lmis = 0;
      for (int i = 0; i < n; i++) begin
         if (got_q[i][7:0] != exp_q[i][7:0]) dmis++;
         if (got_q[i][8] != exp_q[i][8]) lmis++;
      end
      chk(dmis == 0, "R4", "data byte mismatches", dmis, 0);
      chk(lmis == 0, "R5", "tx_last mismatches", lmis, 0);
      chk(got_buf == exp_buf, "R9", "buffer events", got_buf, exp_buf);
      chk(got_frame == exp_frame, "R9", "frame events", got_frame, exp_frame);
      chk(got_bab == exp_bab, "R10", "babble events", got_bab, exp_bab);
      dsc = 0;
      for (int i = 0; i < 64; i++) if (mem[i] != shadow[i]) dsc++;
      chk(dsc == 0, "R6", "descriptor words differing", dsc, 0);
      chk(quiet == 0, "R11", "activity after walk", quiet, 0);
      chk(hold_err == 0, "R12", "output hold violations", hold_err, 0);
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'd20240611);
      for (int i = 0; i < 1024; i++) mem[i] = $urandom;
      clear_desc();

      // R1: reset state
      repeat (4) @(negedge clk);
      chk(!mem_req && !tx_valid && !busy, "R1", "outputs in reset", {mem_req, tx_valid, busy}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!mem_req && !tx_valid && !busy, "R1", "outputs after reset", {mem_req, tx_valid, busy}, 0);
      chk(got_buf + got_frame + got_bab == 0, "R1", "events after reset", got_buf + got_frame + got_bab, 0);

      // R2 R4 R5: two-buffer frame with odd alignments
      set_base(32'h0);
      put_desc(32'h00, 16'h8000, 16'd5, 32'h101);
      put_desc(32'h08, 16'h8800, 16'd3, 32'h203);
      rdy_rand = 1'b0;
      do_run("R2", 1'b0);

      // R3: stop on a non-ready header, pointer kept
      do_run("R3", 1'b0);
      do_run("R3", 1'b0);

      // R8 then R7: unaligned base write, wrap onto a cleared descriptor
      set_base(32'h43);
      put_desc(32'h40, 16'h8800, 16'd4, 32'h300);
      put_desc(32'h48, 16'hA800, 16'd2, 32'h311);
      rdy_rand = 1'b1;
      do_run("R8", 1'b0);
      do_run("R7", 1'b0);

      // R10: truncation at the frame limit, then a fresh frame
      set_base(32'h80);
      put_desc(32'h80, 16'h8000, 16'd2000, 32'h400);
      put_desc(32'h88, 16'h8800, 16'd100, 32'hC00);
      put_desc(32'h90, 16'h8800, 16'd10, 32'h501);
      do_run("R10", 1'b0);

      // R11: activate pulse while busy
      set_base(32'hC0);
      put_desc(32'hC0, 16'h8000, 16'd9, 32'h600);
      put_desc(32'hC8, 16'h8800, 16'd7, 32'h702);
      put_desc(32'hD0, 16'h8800, 16'd6, 32'h7A1);
      do_run("R11", 1'b1);

      // Random rings: R4 R5 R6 R9 R12
      for (int r = 0; r < 24; r++) begin
         int unsigned b, nd;
         clear_desc();
         b = 8 * ($urandom % 4);
         set_base(b);
         nd = 1 + ($urandom % 6);
         for (int k = 0; k < nd; k++) begin
            bit lst, wrp;
            logic [15:0] flg, ln;
            lst = (k == nd - 1) || (($urandom % 3) == 0);
            wrp = (k == nd - 1) && (($urandom % 2) == 0);
            ln  = (k == nd - 1) ? 16'(1 + $urandom % 40) : 16'($urandom % 41);
            flg = 16'h8000 | (16'(lst) << 11) | (16'(wrp) << 13) | 16'($urandom & 32'h00F7);
            put_desc(b + 8 * k, flg, ln, 32'h100 + ($urandom % 32'hE00));
         end
         rdy_rand = (r % 3) != 0;
         do_run("R2", (r % 5) == 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule